// File: doc/BRIEF.md
# Programmable Periodic Soft-Trigger Generator

This block issues a one-clock software trigger pulse at a programmable, regular interval. The interval is built from a fixed time step of 12.5 ms, which a prescaler derives from the clock frequency parameter. One interval lasts N + 2 steps, where N is an 8-bit rate setting. N = 0 therefore gives a 25 ms period (40 Hz), and N = 255 gives 3.2 s (about 0.3 Hz). The period grows linearly with N; it is not a plain division by N.

A control path writes the rate setting through a load strobe. It switches continuous generation on and off with a level enable. Independently of that mode, it can request a single immediate trigger. A new rate setting is captured at once but only shapes the interval that follows the next pulse. Switching continuous mode on starts a fresh interval. Switching it off discards any interval in progress.

Top module: `soft_trig_gen`

## Requirements
- R1: After reset `trig_out` is low, continuous mode is idle and the stored rate setting is 0xFF. Enabling without a load therefore yields a period of 257 steps.
- R2: A high `mult_load` at a clock edge stores `mult_in` as the rate setting N.
- R3: With continuous mode running, pulses repeat every (N + 2) × STEP clock cycles. STEP = CLK_HZ / STEPS_PER_S, which is 12.5 ms at the default of 80 steps per second. N = 0 gives 40 Hz.
- R4: Each periodic pulse on `trig_out` is exactly one clock cycle wide.
- R5: A rate setting loaded during an interval leaves that interval's length unchanged. It applies from the interval that starts at the next pulse.
- R6: While `cont_en` is low, no periodic pulse appears. Dropping `cont_en` before an interval completes suppresses that interval's pulse.
- R7: `manual_req` high at a clock edge drives `trig_out` high for the following cycle, whether or not continuous mode is on.
- R8: A manual request sampled at the same edge as a periodic pulse produces one single-cycle pulse, not two.
- R9: `cont_en` is first sampled high at edge E. The first pulse is then the cycle after edge E + (N + 2) × STEP, so a re-enable always begins a full new interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_en | input | 1 | Continuous generation on (level) |
| mult_in | input | 8 | Rate setting N |
| mult_load | input | 1 | Capture `mult_in` as the new rate setting |
| manual_req | input | 1 | Single immediate trigger request |
| trig_out | output | 1 | Registered trigger pulse |

## Verification
The assertions assume that the prescale count STEP is at least two clock cycles, so two periodic pulses can never fall on adjacent edges. They also treat `manual_req` as a per-cycle request: each cycle it is held high yields a pulse. The stimulus changes every input only on the falling clock edge. It never pulses `mult_load` on the same edge where `cont_en` is first seen high. It uses a shortened clock frequency parameter so that STEP is ten cycles, which keeps even the slowest setting to a few thousand cycles.

// File: rtl/soft_trig_gen.sv
module soft_trig_gen #(
  parameter int CLK_HZ      = 80_000_000,
  parameter int STEPS_PER_S = 80,
  parameter int MULT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cont_en,
  input  logic [MULT_W-1:0] mult_in,
  input  logic              mult_load,
  input  logic              manual_req,
  output logic              trig_out
);

  localparam int STEP = CLK_HZ / STEPS_PER_S;
  localparam int PW   = $clog2(STEP + 1);
  localparam int CW   = MULT_W + 1;

  logic [MULT_W-1:0] mult_q, cur_n;
  logic [PW-1:0]     pre_cnt;
  logic [CW-1:0]     step_cnt;
  logic              en_q, trig_q;

  wire run   = cont_en & en_q;
  wire tick  = run && (pre_cnt == PW'(STEP - 1));
  wire last  = step_cnt == (CW'(cur_n) + CW'(1));
  wire fire  = tick & last;

  assign trig_out = trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q   <= '1;
      cur_n    <= '1;
      pre_cnt  <= '0;
      step_cnt <= '0;
      en_q     <= 1'b0;
      trig_q   <= 1'b0;
    end else begin
      en_q   <= cont_en;
      trig_q <= fire | manual_req;
      if (mult_load) mult_q <= mult_in;
      if (!run) begin
        pre_cnt  <= '0;
        step_cnt <= '0;
        cur_n    <= mult_q;
      end else if (tick) begin
        pre_cnt <= '0;
        if (last) begin
          step_cnt <= '0;
          cur_n    <= mult_q;
        end else begin
          step_cnt <= step_cnt + CW'(1);
        end
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end
  end

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    mult_load |=> mult_q == $past(mult_in));

  a_r5_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fire) |=> $stable(cur_n));

  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  a_r9_enable_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_en && !en_q) |=> (pre_cnt == '0 && step_cnt == '0));

  a_r6_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> (step_cnt == '0 && !fire));

  a_r7_manual_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    manual_req |=> trig_out);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt <= CW'(cur_n) + CW'(1));

endmodule

// File: tb/soft_trig_gen_test.sv
module soft_trig_gen_test;
  localparam int STEP = 10;
  localparam int NV = 5;
  localparam logic [7:0] VN [NV] = '{8'd0, 8'd1, 8'd5, 8'd20, 8'd100};
  localparam int         VP [NV] = '{20, 30, 70, 220, 1020};

  logic clk = 0, rst_n = 0, cont_en = 0, mult_load = 0, manual_req = 0;
  logic [7:0] mult_in = 0;
  logic trig_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  soft_trig_gen #(.CLK_HZ(800), .STEPS_PER_S(80), .MULT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .cont_en(cont_en), .mult_in(mult_in),
    .mult_load(mult_load), .manual_req(manual_req), .trig_out(trig_out));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_pulse(input int limit, output int k);
    k = 0;
    for (int i = 0; i < limit; i++) begin
      cyc(); k++;
      if (trig_out) return;
    end
    k = -1;
  endtask

  task automatic load(input logic [7:0] n);
    mult_in = n; mult_load = 1; cyc(); mult_load = 0; cyc();
  endtask

  task automatic measure(input logic [7:0] n, input int p);
    int k;
    cont_en = 0; cyc(); cyc();
    load(n);
    cont_en = 1;
    wait_pulse(4 * p, k);
    check(k - 1 == p, "R3/R9 first pulse delay", k - 1, p);
    cyc();
    check(trig_out == 0, "R4 pulse width", trig_out, 0);
    wait_pulse(4 * p, k);
    check(k + 1 == p, "R3 repeat period", k + 1, p);
    cont_en = 0; cyc();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k, cnt;
    @(negedge clk); cyc(); cyc();
    check(trig_out == 0, "R1 reset output low", trig_out, 0);
    rst_n = 1; cyc();
    check(trig_out == 0, "R1 idle after reset", trig_out, 0);

    // R1: no load yet, rate setting must be 0xFF -> 257 steps
    cont_en = 1;
    wait_pulse(3000, k);
    check(k - 1 == 257 * STEP, "R1 default setting period", k - 1, 257 * STEP);
    cont_en = 0; cyc();

    // table: R2, R3, R4, R9
    for (int i = 0; i < NV; i++) measure(VN[i], VP[i]);

    // R5: load mid-interval leaves current interval alone
    cont_en = 0; cyc(); load(8'd0);
    cont_en = 1;
    for (int i = 0; i < 5; i++) cyc();
    mult_in = 8'd3; mult_load = 1; cyc(); mult_load = 0;
    wait_pulse(200, k);
    check(k + 6 - 1 == 20, "R5 current interval kept", k + 5, 20);
    wait_pulse(200, k);
    check(k == 50, "R5 new setting after reload", k, 50);
    cont_en = 0; cyc();

    // R6: disable mid-interval suppresses pulse
    load(8'd0);
    cont_en = 1;
    for (int i = 0; i < 15; i++) cyc();
    cont_en = 0;
    cnt = 0;
    for (int i = 0; i < 60; i++) begin cyc(); if (trig_out) cnt++; end
    check(cnt == 0, "R6 no pulse while disabled", cnt, 0);

    // R9: re-enable mid-interval restarts full period
    cont_en = 1;
    for (int i = 0; i < 13; i++) cyc();
    cont_en = 0; cyc();
    cont_en = 1;
    wait_pulse(200, k);
    check(k - 1 == 20, "R9 restart after re-enable", k - 1, 20);
    cont_en = 0; cyc(); cyc();

    // R7: manual pulse with continuous off
    manual_req = 1; cyc(); manual_req = 0;
    check(trig_out == 1, "R7 manual pulse high", trig_out, 1);
    cyc();
    check(trig_out == 0, "R7 manual pulse ends", trig_out, 0);

    // R8: manual coincides with periodic fire edge
    cont_en = 1;
    for (int i = 0; i < 20; i++) begin
      cyc();
      if (trig_out) cnt++;
    end
    manual_req = 1; cyc(); manual_req = 0;
    check(trig_out == 1, "R8 coincident pulse high", trig_out, 1);
    cyc();
    check(trig_out == 0, "R8 coincident single cycle", trig_out, 0);
    cont_en = 0; cyc();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule